// File: doc/BRIEF.md
# Odd-Parity SECDED Codec for Byte Data

This block protects one byte with a Hamming code extended by an overall parity bit, using odd parity for every check. The encoder side takes a byte with a valid strobe and returns a 13-bit protected word one clock later. The decoder side takes a 13-bit word with a valid strobe and, one clock later, returns the recovered byte together with a flag for a corrected single-bit fault, a flag for an uncorrectable double-bit fault, and the position of the corrected bit.

The two directions are independent and can run in the same cycle. Both are pipelined: a new word may be presented on every clock. The registered results hold their last value while the matching valid input is low. Faults that touch three or more bits are not handled.

Top module: `secded_odd_codec`

## Requirements
- R1: In the codeword (bit index = position 0..12), the data byte occupies positions 3, 5, 6, 7, 9, 10, 11, 12, with data bit 7 at position 3 and data bit 0 at position 12; positions 0, 1, 2, 4 and 8 carry check bits.
- R2: For k in 0..3, the check bit at position 2^k makes the number of ones among all positions whose index has bit k set (including itself) odd.
- R3: The bit at position 0 makes the number of ones across all 13 positions odd.
- R4: `encValidOut` equals `encValidIn` of the previous clock; `encCode` is updated only one clock after a cycle with `encValidIn` high and otherwise holds its value.
- R5: A decoder input that satisfies R2 and R3 yields the embedded byte, both flags low and `decErrPos` = 0.
- R6: When the overall parity fails and the failing checks, read as a binary number (check k as bit k), give a position 1..12, the decoder flips that bit, returns the corrected byte, sets `decSingleErr`, clears `decDoubleErr` and reports the position on `decErrPos`.
- R7: When the overall parity fails and every Hamming check passes, the fault is at position 0: the byte is returned unchanged, `decSingleErr` = 1, `decDoubleErr` = 0, `decErrPos` = 0.
- R8: When the overall parity holds but at least one Hamming check fails, `decDoubleErr` = 1, `decSingleErr` = 0, `decErrPos` = 0 and the byte is taken from the data positions without correction.
- R9: `decValidOut` equals `decValidIn` of the previous clock; the decoder results are updated only one clock after a cycle with `decValidIn` high and otherwise hold.
- R10: While `rstN` is low all outputs are zero.
- R11: Byte 0x6B encodes to 13'h1A65; the word 13'h16D6 decodes to byte 0x1D with a single fault at position 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| encValidIn | input | 1 | Byte on `encData` is to be encoded |
| encData | input | 8 | Byte to protect |
| encValidOut | output | 1 | `encCode` holds a new codeword |
| encCode | output | 13 | Protected word, bit index = position |
| decValidIn | input | 1 | Word on `decCode` is to be checked |
| decCode | input | 13 | Received word, bit index = position |
| decValidOut | output | 1 | Decoder results are new |
| decData | output | 8 | Recovered byte |
| decSingleErr | output | 1 | A single fault was found (and corrected where it hit data or check bits) |
| decDoubleErr | output | 1 | An uncorrectable double fault was found |
| decErrPos | output | 4 | Position of the single fault, zero otherwise |

## Verification
The bench sweeps all 256 bytes through the encoder and then feeds the decoder clean words, every single-bit flip and every pair of flips for a spread of bytes. A flip of position 0 is the case most easily gotten wrong: a decoder that only looks at the syndrome would call it clean and drop the single flag, while one that treats it like a data fault would corrupt a data bit. Double flips catch a decoder that mistakes the syndrome for a position and miscorrects, and gaps in the valid inputs catch outputs that update without a request or a valid that does not track its input by exactly one clock.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Strobes issued by the control to the datapath.
  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } secdedStrobeT;

  // Number of Hamming check bits needed for dataW data bits.
  function automatic int parBitsFor(int dataW);
    int r;
    r = 0;
    while ((1 << r) < dataW + r + 1) r++;
    return r;
  endfunction

  function automatic bit isPow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Codeword position of data bit bitIdx (most significant bit placed first).
  function automatic int dataPosOf(int bitIdx, int dataW);
    int want;
    int seen;
    int res;
    want = dataW - 1 - bitIdx;
    seen = 0;
    res  = 0;
    for (int p = 3; p < 2 * dataW + 8; p++) begin
      if (!isPow2(p)) begin
        if (seen == want) res = p;
        seen++;
      end
    end
    return res;
  endfunction

  // Data bit index stored at codeword position pos (pos must be a data slot).
  function automatic int dataIdxAt(int pos, int dataW);
    int ordinal;
    ordinal = 0;
    for (int p = 3; p < pos; p++) begin
      if (!isPow2(p)) ordinal++;
    end
    return dataW - 1 - ordinal;
  endfunction

endpackage

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         encValidIn,
  input  logic         decValidIn,
  output secdedStrobeT stb,
  output logic         encValidOut,
  output logic         decValidOut
);

  always_comb begin
    stb.encLoad = encValidIn;
    stb.decLoad = decValidIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encValidOut <= 1'b0;
      decValidOut <= 1'b0;
    end else begin
      encValidOut <= encValidIn;
      decValidOut <= decValidIn;
    end
  end

  assert_enc_valid_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    encValidIn |=> encValidOut);
  assert_enc_valid_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !encValidIn |=> !encValidOut);
  assert_dec_valid_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    decValidIn |=> decValidOut);
  assert_dec_valid_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !decValidIn |=> !decValidOut);

endmodule

// File: rtl/secded_dpath.sv
module secded_dpath
  import secded_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int PAR_W  = parBitsFor(DATA_W),
  localparam int CODE_W = DATA_W + PAR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  secdedStrobeT      stb,
  input  logic [DATA_W-1:0] encData,
  input  logic [CODE_W-1:0] decCode,
  output logic [CODE_W-1:0] encCode,
  output logic [DATA_W-1:0] decData,
  output logic              decSingleErr,
  output logic              decDoubleErr,
  output logic [PAR_W-1:0]  decErrPos
);

  // Positions covered by Hamming check k (index has bit k set).
  function automatic logic [CODE_W-1:0] groupMask(int k);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p < CODE_W; p++) m[p] = ((p >> k) & 1) == 1;
    return m;
  endfunction

  // ---------------- encoder ----------------
  logic [CODE_W-1:0] spread;     // data placed in its slots, zeros elsewhere
  logic [CODE_W-1:1] encUpper;   // positions 1..CODE_W-1 with Hamming bits
  logic [CODE_W-1:0] encFull;

  for (genvar p = 0; p < CODE_W; p++) begin : gSpread
    if (p > 0 && !isPow2(p)) begin : gData
      assign spread[p] = encData[dataIdxAt(p, DATA_W)];
    end else begin : gHole
      assign spread[p] = 1'b0;
    end
  end

  for (genvar p = 1; p < CODE_W; p++) begin : gUpper
    if (isPow2(p)) begin : gChk
      assign encUpper[p] = ~^(spread & groupMask($clog2(p)));
    end else begin : gCopy
      assign encUpper[p] = spread[p];
    end
  end

  assign encFull = {encUpper, ~^encUpper};

  // ---------------- decoder ----------------
  logic [PAR_W-1:0]  synd;        // bit k set: check k fails
  logic              overallBad;  // even weight across the whole word
  logic [DATA_W-1:0] dataFix;
  logic [DATA_W-1:0] decDataNext;
  logic              singleNext;
  logic              doubleNext;
  logic [PAR_W-1:0]  posNext;

  for (genvar k = 0; k < PAR_W; k++) begin : gSynd
    assign synd[k] = ~^(decCode & groupMask(k));
  end

  assign overallBad = ~^decCode;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : gExtract
    localparam int POS = dataPosOf(gi, DATA_W);
    assign dataFix[gi]     = overallBad && (synd == PAR_W'(POS));
    assign decDataNext[gi] = decCode[POS] ^ dataFix[gi];
  end

  assign singleNext = overallBad;
  assign doubleNext = !overallBad && (synd != '0);
  assign posNext    = overallBad ? synd : '0;

  // ---------------- result registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      encCode <= '0;
    end else if (stb.encLoad) begin
      encCode <= encFull;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decData      <= '0;
      decSingleErr <= 1'b0;
      decDoubleErr <= 1'b0;
      decErrPos    <= '0;
    end else if (stb.decLoad) begin
      decData      <= decDataNext;
      decSingleErr <= singleNext;
      decDoubleErr <= doubleNext;
      decErrPos    <= posNext;
    end
  end

  assert_enc_odd_weight_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.encLoad |=> (^encCode));
  assert_enc_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.encLoad |=> $stable(encCode));
  assert_dec_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.decLoad |=> $stable({decData, decSingleErr, decDoubleErr, decErrPos}));
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({decSingleErr, decDoubleErr}));
  assert_parity_ok_no_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.decLoad && (^decCode)) |=> !decSingleErr);
  assert_double_pos_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    decDoubleErr |-> (decErrPos == '0));

endmodule

// File: rtl/secded_odd_codec.sv
module secded_odd_codec
  import secded_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int PAR_W  = parBitsFor(DATA_W),
  localparam int CODE_W = DATA_W + PAR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encValidIn,
  input  logic [DATA_W-1:0] encData,
  output logic              encValidOut,
  output logic [CODE_W-1:0] encCode,
  input  logic              decValidIn,
  input  logic [CODE_W-1:0] decCode,
  output logic              decValidOut,
  output logic [DATA_W-1:0] decData,
  output logic              decSingleErr,
  output logic              decDoubleErr,
  output logic [PAR_W-1:0]  decErrPos
);

  secdedStrobeT stb;

  secded_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .encValidIn (encValidIn),
    .decValidIn (decValidIn),
    .stb        (stb),
    .encValidOut(encValidOut),
    .decValidOut(decValidOut)
  );

  secded_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .encData     (encData),
    .decCode     (decCode),
    .encCode     (encCode),
    .decData     (decData),
    .decSingleErr(decSingleErr),
    .decDoubleErr(decDoubleErr),
    .decErrPos   (decErrPos)
  );

endmodule

// File: tb/tb_secded_odd_codec.sv
`timescale 1ns/1ps
module tb_secded_odd_codec;

  logic        clk = 1'b0;
  logic        rstN;
  logic        encValidIn;
  logic [7:0]  encData;
  logic        encValidOut;
  logic [12:0] encCode;
  logic        decValidIn;
  logic [12:0] decCode;
  logic        decValidOut;
  logic [7:0]  decData;
  logic        decSingleErr;
  logic        decDoubleErr;
  logic [3:0]  decErrPos;

  always #10 clk = ~clk;  // 50 MHz

  secded_odd_codec dut (
    .clk(clk), .rstN(rstN),
    .encValidIn(encValidIn), .encData(encData),
    .encValidOut(encValidOut), .encCode(encCode),
    .decValidIn(decValidIn), .decCode(decCode),
    .decValidOut(decValidOut), .decData(decData),
    .decSingleErr(decSingleErr), .decDoubleErr(decDoubleErr),
    .decErrPos(decErrPos)
  );

  int checks = 0;
  int errors = 0;

  // data slot list, most significant data bit first
  int slot[8] = '{3, 5, 6, 7, 9, 10, 11, 12};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] refEncode(logic [7:0] d);
    logic [12:0] c;
    int ones;
    c = '0;
    for (int j = 0; j < 8; j++) c[slot[j]] = d[7-j];
    for (int k = 0; k < 4; k++) begin
      ones = 0;
      for (int p = 1; p < 13; p++)
        if (((p >> k) & 1) == 1 && p != (1 << k)) ones += int'(c[p]);
      c[1 << k] = (ones % 2 == 0);
    end
    ones = 0;
    for (int p = 1; p < 13; p++) ones += int'(c[p]);
    c[0] = (ones % 2 == 0);
    return c;
  endfunction

  function automatic logic [7:0] slotsOf(logic [12:0] c);
    logic [7:0] d;
    for (int j = 0; j < 8; j++) d[7-j] = c[slot[j]];
    return d;
  endfunction

  // Behavioural decode: XOR of indices of set bits is 4'hF for a clean odd word.
  task automatic refDecode(input logic [12:0] c, output logic [7:0] d,
                           output logic s, output logic dbl, output logic [3:0] pos);
    int x;
    int cnt;
    int syn;
    logic [12:0] fixed;
    x = 0; cnt = 0;
    for (int p = 0; p < 13; p++) if (c[p]) begin x = x ^ p; cnt++; end
    syn = (~x) & 15;
    fixed = c;
    s = 1'b0; dbl = 1'b0; pos = 4'd0;
    if (cnt % 2 == 0) begin
      s = 1'b1;
      pos = 4'(syn);
      if (syn < 13) fixed[syn] = ~fixed[syn];
    end else if (syn != 0) begin
      dbl = 1'b1;
    end
    d = slotsOf(fixed);
  endtask

  // ---------------- reference model, updated every clock ----------------
  logic        expEncValid, expDecValid, expS, expD;
  logic [12:0] expEncCode;
  logic [7:0]  expEncData, expDecData;
  logic [3:0]  expPos;
  string       decTag = "R5";
  string       expDecTag = "R5";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expEncValid <= 1'b0; expDecValid <= 1'b0;
      expEncCode <= '0; expEncData <= '0;
      expDecData <= '0; expS <= 1'b0; expD <= 1'b0; expPos <= '0;
    end else begin
      expEncValid <= encValidIn;
      expDecValid <= decValidIn;
      if (encValidIn) begin
        expEncCode <= refEncode(encData);
        expEncData <= encData;
      end
      if (decValidIn) begin
        logic [7:0] d; logic s, dd; logic [3:0] ps;
        refDecode(decCode, d, s, dd, ps);
        expDecData <= d; expS <= s; expD <= dd; expPos <= ps;
        expDecTag <= decTag;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 encValidOut", 32'(encValidOut), 32'(expEncValid));
      chk("R4 encCode", 32'(encCode), 32'(expEncCode));
      chk("R9 decValidOut", 32'(decValidOut), 32'(expDecValid));
      chk({expDecTag, " decData"}, 32'(decData), 32'(expDecData));
      chk({expDecTag, " decSingleErr"}, 32'(decSingleErr), 32'(expS));
      chk({expDecTag, " decDoubleErr"}, 32'(decDoubleErr), 32'(expD));
      chk({expDecTag, " decErrPos"}, 32'(decErrPos), 32'(expPos));
      if (encValidOut) begin
        int ones;
        chk("R1 data slots", 32'(slotsOf(encCode)), 32'(expEncData));
        for (int k = 0; k < 4; k++) begin
          ones = 0;
          for (int p = 1; p < 13; p++) if (((p >> k) & 1) == 1) ones += int'(encCode[p]);
          chk("R2 group odd", 32'(ones % 2), 32'd1);
        end
        ones = 0;
        for (int p = 0; p < 13; p++) ones += int'(encCode[p]);
        chk("R3 total odd", 32'(ones % 2), 32'd1);
      end
    end
  end

  task automatic sendDec(string tag, logic [12:0] c);
    @(negedge clk);
    decTag = tag;
    decValidIn = 1'b1;
    decCode = c;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] vals[6];
    vals = '{8'h00, 8'hFF, 8'h6B, 8'hA5, 8'h3C, 8'h81};
    rstN = 1'b0;
    encValidIn = 1'b0; encData = '0;
    decValidIn = 1'b0; decCode = '0;
    repeat (3) @(negedge clk);
    // R10: everything zero in reset
    chk("R10 reset outputs",
        32'({encValidOut, encCode, decValidOut, decData, decSingleErr, decDoubleErr, decErrPos}), 32'd0);
    rstN = 1'b1;

    // encoder sweep with gaps (R1..R4)
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      encValidIn = (v % 7 != 3);
      encData = 8'(v);
    end
    @(negedge clk);
    encValidIn = 1'b0;
    encData = 8'h55;

    // decoder scenarios
    foreach (vals[i]) begin
      logic [12:0] c;
      c = refEncode(vals[i]);
      sendDec("R5", c);
      @(negedge clk); decValidIn = 1'b0; decCode = ~c;  // gap: must not update (R9)
      for (int p = 1; p < 13; p++) sendDec("R6", c ^ (13'd1 << p));
      sendDec("R7", c ^ 13'd1);
      for (int p = 0; p < 13; p++)
        for (int q = p + 1; q < 13; q++)
          sendDec("R8", c ^ (13'd1 << p) ^ (13'd1 << q));
    end
    @(negedge clk);
    decValidIn = 1'b0;

    // R11 golden vectors
    encValidIn = 1'b1; encData = 8'h6B;
    decValidIn = 1'b1; decCode = 13'h16D6; decTag = "R11";
    @(negedge clk);
    encValidIn = 1'b0; decValidIn = 1'b0;
    chk("R11 encode 0x6B", 32'(encCode), 32'h1A65);
    chk("R11 decode data", 32'(decData), 32'h1D);
    chk("R11 decode single", 32'(decSingleErr), 32'd1);
    chk("R11 decode pos", 32'(decErrPos), 32'd6);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule